// File: doc/BRIEF.md
# PCI-to-PCI Bridge Forwarding Window Decoder

This block holds the part of a type-1 (bridge) configuration header that describes where the bridge forwards traffic. It has three address windows: I/O, non-prefetchable memory and prefetchable memory. It also stores the bus-number dword, the secondary latency timer and the bridge control word. It supplies the read-only capability and identity bits of the header.

A simple dword-addressed configuration port writes the registers under byte enables and reads them back combinationally. A decode port takes a 64-bit address and a two-bit space code and returns `fwd_hit` in the same cycle when the address lies inside the window of that space. A `dis_fwd` command closes the windows by placing every base above its limit.

Each write that touches a window register raises `remap_pulse` for one cycle, and so does each `dis_fwd` command. The surrounding fabric uses this pulse to rebuild its own routing.

The pulse comes from a three-state Moore machine:
- States: `ST_QUIET` (no change seen), `ST_WR_SEEN` (a window write was seen in the previous cycle) and `ST_DIS_SEEN` (a disable command was seen in the previous cycle).
- Transitions: from any state, a `dis_fwd` cycle leads to `ST_DIS_SEEN`. Otherwise a window-touching write leads to `ST_WR_SEEN`. Otherwise the next state is `ST_QUIET`.
- Output: the pulse is high in both SEEN states.

Top module: `pcib_window_decoder`

## Requirements
- R1: After reset, every stored bit reads zero. This covers dword 0x18 (bus numbers, latency timer), the masked base/limit bits, both prefetchable upper dwords (0x28, 0x2C), the I/O upper dword (0x30) and the bridge control word (bits 31:16 of 0x3C). `remap_pulse` is low.
- R2: Read-only identity bits are fixed. Dword 0x04 reads 0x00A00000 (66 MHz and fast back-to-back capable). Dword 0x0C bits 23:16 read {MULTI_FN, 7'h01}. Bits 31:16 of dword 0x1C read 0x00A0.
- R3: A write changes only the bytes whose enable is set, and only their writable bits. Bits 3:0 of the I/O base and I/O limit bytes (0x1C, 0x1D) read 1 when IO32 is set. Bits 3:0 of the prefetchable base and limit words (0x24, 0x26) read 1 when PREF64 is set. The memory type nibbles read 0.
- R4: In space code 0 (I/O), the base is {I/O base upper word at 0x30, bits 7:4 of 0x1C, 12'h000}. The limit is {upper word at 0x32, bits 7:4 of 0x1D, 12'hFFF}. The upper words are used only when IO32 is set. A hit needs address bits 63:32 to be zero and base ≤ address ≤ limit.
- R5: In space code 1 (memory), the base is {bits 15:4 of word 0x20, 20'h0} and the limit is {bits 15:4 of word 0x22, 20'hFFFFF}. A hit needs base ≤ address ≤ limit.
- R6: In space code 2 (prefetchable), the window is built like R5 from words 0x24 and 0x26. When PREF64 is set, dwords 0x28 and 0x2C supply bits 63:32 of the base and the limit.
- R7: Space code 3 never hits.
- R8: `remap_pulse` is high in the cycle after either of two events, and low otherwise:
  - a write with an enabled byte at offsets 0x1C–0x1D or 0x20–0x33;
  - a `dis_fwd` cycle.
- R9: `dis_fwd` does four things, and wins over a write to the same fields in the same cycle:
  - sets every masked base bit to one;
  - clears every masked limit bit;
  - zeroes dwords 0x28 and 0x2C;
  - leaves the I/O upper words as they are.

  As a result, the memory and prefetchable windows never hit in the following cycle.
- R10: Dwords that are not implemented read zero, and writes to them or to read-only bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dw_addr | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 32 | Combinational read data of the addressed dword |
| dis_fwd | input | 1 | Disable-forwarding command |
| dec_space | input | 2 | Space code: 0 I/O, 1 memory, 2 prefetchable, 3 none |
| dec_addr | input | 64 | Address to decode |
| fwd_hit | output | 1 | Address falls in the selected window |
| remap_pulse | output | 1 | One-cycle window-change event |

## Verification
The bench targets the inclusive window edges: base−1, base, limit and limit+1 in each space. A design that drops the 0xFFF or 0xFFFFF padding, or compares with strict inequalities, misses a hit at the limit or at the base. It also drives I/O addresses with a nonzero upper half and prefetchable addresses whose upper dword differs from the window's, which catches a decoder that ignores the extension registers.

The bench probes the bytes at the edges of the remap span (0x1C–0x1D touched, 0x1E, 0x3C and byte enables of zero untouched). A wrong span shows as a missing or stray pulse. It also issues a disable command in the same cycle as a window write, where a design that lets the write win would leave a window open.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
    localparam int ADDR_W    = 64;
    localparam int DW_W      = 32;
    localparam int BE_W      = DW_W / 8;
    localparam int CFG_IDX_W = 6;
    localparam int NUM_RW    = 8;
    localparam int NUM_WIN   = 3;

    typedef enum logic [1:0] {
        SPACE_IO   = 2'd0,
        SPACE_MEM  = 2'd1,
        SPACE_PREF = 2'd2,
        SPACE_NONE = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        ST_QUIET    = 2'd0,
        ST_WR_SEEN  = 2'd1,
        ST_DIS_SEEN = 2'd2
    } remap_st_e;

    localparam int WIN_IO   = 0;
    localparam int WIN_MEM  = 1;
    localparam int WIN_PREF = 2;

    // slot numbering of the writable dwords
    localparam int SLOT_BUS  = 0;
    localparam int SLOT_IO   = 1;
    localparam int SLOT_MEM  = 2;
    localparam int SLOT_PREF = 3;
    localparam int SLOT_PBU  = 4;
    localparam int SLOT_PLU  = 5;
    localparam int SLOT_IOU  = 6;
    localparam int SLOT_BCTL = 7;

    localparam logic [CFG_IDX_W-1:0] DWI_STATUS = 6'h01;
    localparam logic [CFG_IDX_W-1:0] DWI_HDR    = 6'h03;
    localparam logic [7:0]           STAT_CAPS  = 8'hA0;

    localparam logic [CFG_IDX_W-1:0] SLOT_DWI [0:NUM_RW-1] =
        '{6'h06, 6'h07, 6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0F};

    localparam logic [DW_W-1:0] SLOT_WMASK [0:NUM_RW-1] =
        '{32'hFFFF_FFFF, 32'h0000_F0F0, 32'hFFF0_FFF0, 32'hFFF0_FFF0,
          32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000};

    // disable command: q = (q & AND) | OR
    localparam logic [DW_W-1:0] SLOT_DIS_AND [0:NUM_RW-1] =
        '{32'hFFFF_FFFF, 32'hFFFF_0FFF, 32'h0000_FFFF, 32'h0000_FFFF,
          32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};

    localparam logic [DW_W-1:0] SLOT_DIS_OR [0:NUM_RW-1] =
        '{32'h0000_0000, 32'h0000_00F0, 32'h0000_FFF0, 32'h0000_FFF0,
          32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000};

    // byte lanes whose write raises the remap event
    localparam logic [BE_W-1:0] SLOT_REMAP_BE [0:NUM_RW-1] =
        '{4'b0000, 4'b0011, 4'b1111, 4'b1111,
          4'b1111, 4'b1111, 4'b1111, 4'b0000};
endpackage

// File: rtl/pcib_dword_reg.sv
module pcib_dword_reg
    import pcib_pkg::*;
#(
    parameter logic [DW_W-1:0] WMASK   = '1,
    parameter logic [DW_W-1:0] DIS_AND = '1,
    parameter logic [DW_W-1:0] DIS_OR  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [BE_W-1:0] be,
    input  logic [DW_W-1:0] wdata,
    input  logic            dis,
    output logic [DW_W-1:0] q
);
    logic [DW_W-1:0] lane_mask;
    logic [DW_W-1:0] merged;
    logic [DW_W-1:0] nxt;

    generate
        for (genvar k = 0; k < BE_W; k++) begin : g_lane
            assign lane_mask[8*k +: 8] = {8{be[k]}};
        end
    endgenerate

    always_comb begin
        merged = wr_en ? ((q & ~lane_mask) | (wdata & lane_mask & WMASK)) : q;
        nxt    = dis ? ((merged & DIS_AND) | DIS_OR) : merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/pcib_range_cmp.sv
module pcib_range_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] addr,
    input  logic         en,
    output logic         hit
);
    assign hit = en && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/pcib_remap_fsm.sv
module pcib_remap_fsm
    import pcib_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_wr,
    input  logic dis,
    output logic remap_pulse
);
    remap_st_e state, state_nxt;

    always_comb begin
        if (dis)         state_nxt = ST_DIS_SEEN;
        else if (win_wr) state_nxt = ST_WR_SEEN;
        else             state_nxt = ST_QUIET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_QUIET:    remap_pulse = 1'b0;
            ST_WR_SEEN:  remap_pulse = 1'b1;
            ST_DIS_SEEN: remap_pulse = 1'b1;
            default:     remap_pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcib_cfg_regs.sv
module pcib_cfg_regs
    import pcib_pkg::*;
#(
    parameter bit IO32     = 1'b1,
    parameter bit PREF64   = 1'b1,
    parameter bit MULTI_FN = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [BE_W-1:0]      cfg_be,
    input  logic [DW_W-1:0]      cfg_wdata,
    input  logic                 cfg_we,
    input  logic                 dis_fwd,
    output logic [DW_W-1:0]      cfg_rdata,
    output logic                 win_wr,
    output logic [3:0]           io_b,
    output logic [3:0]           io_l,
    output logic [15:0]          io_bu,
    output logic [15:0]          io_lu,
    output logic [11:0]          mem_b,
    output logic [11:0]          mem_l,
    output logic [11:0]          pf_b,
    output logic [11:0]          pf_l,
    output logic [31:0]          pf_bu,
    output logic [31:0]          pf_lu
);
    logic [NUM_RW-1:0][DW_W-1:0] slot_q;
    logic [NUM_RW-1:0]           slot_sel;

    generate
        for (genvar i = 0; i < NUM_RW; i++) begin : g_slot
            assign slot_sel[i] = (cfg_idx == SLOT_DWI[i]);
            pcib_dword_reg #(
                .WMASK   (SLOT_WMASK[i]),
                .DIS_AND (SLOT_DIS_AND[i]),
                .DIS_OR  (SLOT_DIS_OR[i])
            ) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (cfg_we & slot_sel[i]),
                .be    (cfg_be),
                .wdata (cfg_wdata),
                .dis   (dis_fwd),
                .q     (slot_q[i])
            );
        end
    endgenerate

    function automatic logic [DW_W-1:0] ro_bits(input logic [CFG_IDX_W-1:0] idx);
        logic [DW_W-1:0] v;
        v = '0;
        if (idx == DWI_STATUS) v[23:16] = STAT_CAPS;
        if (idx == DWI_HDR)    v[23:16] = {MULTI_FN, 7'h01};
        if (idx == SLOT_DWI[SLOT_IO]) begin
            v[23:16] = STAT_CAPS;
            v[0]     = IO32;
            v[8]     = IO32;
        end
        if (idx == SLOT_DWI[SLOT_PREF]) begin
            v[0]  = PREF64;
            v[16] = PREF64;
        end
        return v;
    endfunction

    always_comb begin
        cfg_rdata = ro_bits(cfg_idx);
        for (int i = 0; i < NUM_RW; i++) begin
            if (slot_sel[i]) cfg_rdata = cfg_rdata | slot_q[i];
        end
    end

    always_comb begin
        win_wr = 1'b0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (cfg_we && slot_sel[i] && (|(cfg_be & SLOT_REMAP_BE[i]))) win_wr = 1'b1;
        end
    end

    assign io_b  = slot_q[SLOT_IO][7:4];
    assign io_l  = slot_q[SLOT_IO][15:12];
    assign io_bu = slot_q[SLOT_IOU][15:0];
    assign io_lu = slot_q[SLOT_IOU][31:16];
    assign mem_b = slot_q[SLOT_MEM][15:4];
    assign mem_l = slot_q[SLOT_MEM][31:20];
    assign pf_b  = slot_q[SLOT_PREF][15:4];
    assign pf_l  = slot_q[SLOT_PREF][31:20];
    assign pf_bu = slot_q[SLOT_PBU];
    assign pf_lu = slot_q[SLOT_PLU];
endmodule

// File: rtl/pcib_window_decoder.sv
module pcib_window_decoder
    import pcib_pkg::*;
#(
    parameter bit IO32     = 1'b1,
    parameter bit PREF64   = 1'b1,
    parameter bit MULTI_FN = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_IDX_W-1:0] cfg_dw_addr,
    input  logic [BE_W-1:0]      cfg_be,
    input  logic [DW_W-1:0]      cfg_wdata,
    input  logic                 cfg_we,
    output logic [DW_W-1:0]      cfg_rdata,
    input  logic                 dis_fwd,
    input  logic [1:0]           dec_space,
    input  logic [ADDR_W-1:0]    dec_addr,
    output logic                 fwd_hit,
    output logic                 remap_pulse
);
    localparam int HALF_W = ADDR_W / 2;

    logic        win_wr;
    logic [3:0]  io_b, io_l;
    logic [15:0] io_bu, io_lu;
    logic [11:0] mem_b, mem_l, pf_b, pf_l;
    logic [31:0] pf_bu, pf_lu;

    pcib_cfg_regs #(
        .IO32     (IO32),
        .PREF64   (PREF64),
        .MULTI_FN (MULTI_FN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_idx   (cfg_dw_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_we    (cfg_we),
        .dis_fwd   (dis_fwd),
        .cfg_rdata (cfg_rdata),
        .win_wr    (win_wr),
        .io_b      (io_b),
        .io_l      (io_l),
        .io_bu     (io_bu),
        .io_lu     (io_lu),
        .mem_b     (mem_b),
        .mem_l     (mem_l),
        .pf_b      (pf_b),
        .pf_l      (pf_l),
        .pf_bu     (pf_bu),
        .pf_lu     (pf_lu)
    );

    pcib_remap_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_wr      (win_wr),
        .dis         (dis_fwd),
        .remap_pulse (remap_pulse)
    );

    logic [NUM_WIN-1:0][ADDR_W-1:0] w_lo, w_hi;
    logic [NUM_WIN-1:0]             w_en, w_hit;

    // window bounds with granularity padding
    assign w_lo[WIN_IO]   = {32'h0, (IO32 ? io_bu : 16'h0), io_b, 12'h000};
    assign w_hi[WIN_IO]   = {32'h0, (IO32 ? io_lu : 16'h0), io_l, 12'hFFF};
    assign w_lo[WIN_MEM]  = {32'h0, mem_b, 20'h00000};
    assign w_hi[WIN_MEM]  = {32'h0, mem_l, 20'hFFFFF};
    assign w_lo[WIN_PREF] = {(PREF64 ? pf_bu : 32'h0), pf_b, 20'h00000};
    assign w_hi[WIN_PREF] = {(PREF64 ? pf_lu : 32'h0), pf_l, 20'hFFFFF};

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            if (g == WIN_IO) begin : g_io_en
                assign w_en[g] = (dec_space == SPACE_IO) && (dec_addr[ADDR_W-1:HALF_W] == '0);
            end else begin : g_mem_en
                assign w_en[g] = (dec_space == 2'(g));
            end
            pcib_range_cmp #(.W(ADDR_W)) u_cmp (
                .lo   (w_lo[g]),
                .hi   (w_hi[g]),
                .addr (dec_addr),
                .en   (w_en[g]),
                .hit  (w_hit[g])
            );
        end
    endgenerate

    assign fwd_hit = |w_hit;
endmodule

// File: rtl/pcib_window_decoder_chk.sv
module pcib_window_decoder_chk
    import pcib_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [CFG_IDX_W-1:0] cfg_dw_addr,
    input logic [BE_W-1:0]      cfg_be,
    input logic                 cfg_we,
    input logic                 dis_fwd,
    input logic [1:0]           dec_space,
    input logic [ADDR_W-1:0]    dec_addr,
    input logic                 fwd_hit,
    input logic                 remap_pulse
);
    logic span_wr;
    assign span_wr = cfg_we &&
        (((cfg_dw_addr == 6'h07) && (|cfg_be[1:0])) ||
         ((cfg_dw_addr >= 6'h08) && (cfg_dw_addr <= 6'h0C) && (|cfg_be)));

    assert_remap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        remap_pulse |-> $past(span_wr || dis_fwd));

    assert_remap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(span_wr || dis_fwd) |-> !remap_pulse);

    assert_none_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_space == 2'd3) |-> !fwd_hit);

    assert_io_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_space == 2'd0) && (dec_addr[63:32] != 32'h0)) |-> !fwd_hit);

    assert_closed_after_dis_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dis_fwd) && (dec_space != 2'd0)) |-> !fwd_hit);
endmodule

bind pcib_window_decoder pcib_window_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_dw_addr (cfg_dw_addr),
    .cfg_be      (cfg_be),
    .cfg_we      (cfg_we),
    .dis_fwd     (dis_fwd),
    .dec_space   (dec_space),
    .dec_addr    (dec_addr),
    .fwd_hit     (fwd_hit),
    .remap_pulse (remap_pulse)
);

// File: tb/pcib_window_decoder_bench.sv
`timescale 1ns/1ps
module pcib_window_decoder_bench;
    localparam bit IO32   = 1'b1;
    localparam bit PREF64 = 1'b1;
    localparam bit MF     = 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_rdata;
    logic        dis_fwd = 1'b0;
    logic [1:0]  dec_space = 2'd3;
    logic [63:0] dec_addr = '0;
    logic        fwd_hit;
    logic        remap_pulse;

    always #2 clk = ~clk;

    pcib_window_decoder u_pcib_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
        .dis_fwd(dis_fwd), .dec_space(dec_space), .dec_addr(dec_addr),
        .fwd_hit(fwd_hit), .remap_pulse(remap_pulse)
    );

    // behavioural reference: byte image of the header
    logic [7:0] mb [0:255];
    bit         exp_remap;
    string      phase = "R1";
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;

    function automatic logic [7:0] wm(int o);
        if (o >= 8'h18 && o <= 8'h1B) return 8'hFF;
        if (o == 8'h1C || o == 8'h1D) return 8'hF0;
        if (o >= 8'h20 && o <= 8'h27) return (o % 2 == 0) ? 8'hF0 : 8'hFF;
        if (o >= 8'h28 && o <= 8'h33) return 8'hFF;
        if (o == 8'h3E || o == 8'h3F) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [7:0] ro(int o);
        if (o == 8'h06 || o == 8'h1E) return 8'hA0;
        if (o == 8'h0E) return {MF, 7'h01};
        if (o == 8'h1C || o == 8'h1D) return {7'h0, IO32};
        if (o == 8'h24 || o == 8'h26) return {7'h0, PREF64};
        return 8'h00;
    endfunction

    function automatic logic [63:0] wlo(int sp);
        case (sp)
            0: return ((IO32 ? 64'({mb[8'h31], mb[8'h30]}) : 64'h0) << 16) |
                      (64'(mb[8'h1C] & 8'hF0) << 8);
            1: return 64'({mb[8'h21], mb[8'h20]} & 16'hFFF0) << 16;
            default: return ((PREF64 ? 64'({mb[8'h2B], mb[8'h2A], mb[8'h29], mb[8'h28]}) : 64'h0) << 32) |
                      (64'({mb[8'h25], mb[8'h24]} & 16'hFFF0) << 16);
        endcase
    endfunction

    function automatic logic [63:0] whi(int sp);
        case (sp)
            0: return ((IO32 ? 64'({mb[8'h33], mb[8'h32]}) : 64'h0) << 16) |
                      (64'(mb[8'h1D] & 8'hF0) << 8) | 64'hFFF;
            1: return (64'({mb[8'h23], mb[8'h22]} & 16'hFFF0) << 16) | 64'hFFFFF;
            default: return ((PREF64 ? 64'({mb[8'h2F], mb[8'h2E], mb[8'h2D], mb[8'h2C]}) : 64'h0) << 32) |
                      (64'({mb[8'h27], mb[8'h26]} & 16'hFFF0) << 16) | 64'hFFFFF;
        endcase
    endfunction

    function automatic bit exp_hit(int sp, logic [63:0] a);
        if (sp == 3) return 1'b0;
        if (sp == 0 && a[63:32] != 32'h0) return 1'b0;
        return (wlo(sp) <= a) && (a <= whi(sp));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mb[i] = 8'h00;
            exp_remap = 1'b0;
        end else begin
            bit touched;
            touched = 1'b0;
            if (cfg_we) begin
                for (int k = 0; k < 4; k++) begin
                    int o;
                    o = int'(cfg_dw_addr) * 4 + k;
                    if (cfg_be[k]) begin
                        mb[o] = cfg_wdata[8*k +: 8] & wm(o);
                        if (o == 8'h1C || o == 8'h1D || (o >= 8'h20 && o <= 8'h33)) touched = 1'b1;
                    end
                end
            end
            if (dis_fwd) begin
                mb[8'h1C] = 8'hF0; mb[8'h1D] = 8'h00;
                mb[8'h20] = 8'hF0; mb[8'h21] = 8'hFF; mb[8'h22] = 8'h00; mb[8'h23] = 8'h00;
                mb[8'h24] = 8'hF0; mb[8'h25] = 8'hFF; mb[8'h26] = 8'h00; mb[8'h27] = 8'h00;
                for (int o = 8'h28; o <= 8'h2F; o++) mb[o] = 8'h00;
            end
            exp_remap = touched || dis_fwd;
        end
    end

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (phase %s): actual %h expected %h", what, phase, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] er;
            string rtag;
            for (int k = 0; k < 4; k++) begin
                int o;
                o = int'(cfg_dw_addr) * 4 + k;
                er[8*k +: 8] = mb[o] | ro(o);
            end
            if (cfg_dw_addr >= 6'h07 && cfg_dw_addr <= 6'h0C)       rtag = "R3 window readback";
            else if (cfg_dw_addr == 6'h01 || cfg_dw_addr == 6'h03) rtag = "R2 identity readback";
            else if (cfg_dw_addr == 6'h06 || cfg_dw_addr == 6'h0F) rtag = "R1 stored readback";
            else                                                   rtag = "R10 unimplemented readback";
            chk(rtag, 64'(cfg_rdata), 64'(er));
            case (dec_space)
                2'd0: chk("R4 io hit", 64'(fwd_hit), 64'(exp_hit(0, dec_addr)));
                2'd1: chk("R5 mem hit", 64'(fwd_hit), 64'(exp_hit(1, dec_addr)));
                2'd2: chk("R6 pref hit", 64'(fwd_hit), 64'(exp_hit(2, dec_addr)));
                default: chk("R7 none hit", 64'(fwd_hit), 64'h0);
            endcase
            chk("R8 remap", 64'(remap_pulse), 64'(exp_remap));
        end
    end

    task automatic drive(bit we, logic [7:0] off, logic [3:0] be, logic [31:0] d,
                         bit dis, logic [1:0] sp, logic [63:0] a);
        @(posedge clk);
        #1;
        cfg_we = we; cfg_dw_addr = off[7:2]; cfg_be = be; cfg_wdata = d;
        dis_fwd = dis; dec_space = sp; dec_addr = a;
    endtask

    task automatic wr(logic [7:0] off, logic [3:0] be, logic [31:0] d);
        drive(1'b1, off, be, d, 1'b0, 2'd3, 64'h0);
    endtask

    task automatic rd(logic [7:0] off);
        drive(1'b0, off, 4'h0, 32'h0, 1'b0, 2'd3, 64'h0);
    endtask

    task automatic dc(logic [1:0] sp, logic [63:0] a);
        drive(1'b0, 8'h1C, 4'h0, 32'h0, 1'b0, sp, a);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        phase = "R1";
        rd(8'h18); rd(8'h1C); rd(8'h20); rd(8'h24); rd(8'h28);
        rd(8'h2C); rd(8'h30); rd(8'h3C);
        phase = "R2";
        rd(8'h04); rd(8'h0C);

        phase = "R3";
        wr(8'h18, 4'b0101, 32'hA5A5_A5A5); rd(8'h18);
        wr(8'h1C, 4'b1111, 32'hFFFF_FFFF); rd(8'h1C);
        wr(8'h24, 4'b0011, 32'hFFFF_FFFF); rd(8'h24);

        phase = "R4";
        wr(8'h1C, 4'b0011, 32'h0000_3020);
        wr(8'h30, 4'b1111, 32'h0001_0001);
        dc(2'd0, 64'h0001_1FFF); dc(2'd0, 64'h0001_2000); dc(2'd0, 64'h0001_3FFF);
        dc(2'd0, 64'h0001_4000); dc(2'd0, 64'h1_0001_2000);

        phase = "R5";
        wr(8'h20, 4'b1111, 32'h0050_0010);
        dc(2'd1, 64'h000F_FFFF); dc(2'd1, 64'h0010_0000); dc(2'd1, 64'h005F_FFFF);
        dc(2'd1, 64'h0060_0000); dc(2'd0, 64'h0010_0000);

        phase = "R6";
        wr(8'h24, 4'b1111, 32'h0020_0010);
        wr(8'h28, 4'b1111, 32'h0000_0002);
        wr(8'h2C, 4'b1111, 32'h0000_0002);
        dc(2'd2, 64'h2_0010_0000); dc(2'd2, 64'h2_002F_FFFF); dc(2'd2, 64'h0_0010_0000);
        dc(2'd2, 64'h2_0030_0000); dc(2'd2, 64'h2_000F_FFFF);

        phase = "R7";
        dc(2'd3, 64'h0010_0000); dc(2'd3, 64'h2_0010_0000);

        phase = "R8";
        wr(8'h18, 4'b1111, 32'h0102_0304);
        wr(8'h1C, 4'b0100, 32'h00FF_0000);
        wr(8'h20, 4'b0000, 32'hFFFF_FFFF);
        wr(8'h3C, 4'b1111, 32'h1234_5678);
        wr(8'h30, 4'b1000, 32'h0100_0000);
        wr(8'h1C, 4'b0010, 32'h0000_3000);
        wr(8'h30, 4'b1111, 32'h0001_0001);
        rd(8'h3C); rd(8'h30);

        phase = "R9";
        drive(1'b0, 8'h20, 4'h0, 32'h0, 1'b1, 2'd1, 64'h0010_0000);
        dc(2'd1, 64'h0010_0000); dc(2'd2, 64'h2_0010_0000); dc(2'd0, 64'h0001_2000);
        rd(8'h1C); rd(8'h20); rd(8'h24); rd(8'h28); rd(8'h2C); rd(8'h30);
        wr(8'h20, 4'b1111, 32'h0050_0010);
        drive(1'b1, 8'h20, 4'b1111, 32'h0050_0010, 1'b1, 2'd1, 64'h0010_0000);
        dc(2'd1, 64'h0010_0000); rd(8'h20);

        phase = "R10";
        wr(8'h40, 4'b1111, 32'hDEAD_BEEF); rd(8'h40);
        wr(8'h04, 4'b1111, 32'hFFFF_FFFF); rd(8'h04);
        wr(8'h0C, 4'b1111, 32'hFFFF_FFFF); rd(8'h0C); rd(8'h08);

        phase = "R4/R5/R6 mixed";
        for (int n = 0; n < 600; n++) begin
            logic [7:0]  offs [0:10];
            logic [7:0]  off;
            logic [1:0]  sp;
            logic [63:0] a;
            int          pick;
            offs = '{8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h3C, 8'h04, 8'h0C, 8'h50};
            off  = offs[$urandom_range(0, 10)];
            sp   = 2'($urandom_range(0, 3));
            pick = $urandom_range(0, 4);
            case (pick)
                0: a = wlo((sp == 3) ? 1 : int'(sp)) - 64'd1;
                1: a = wlo((sp == 3) ? 1 : int'(sp));
                2: a = whi((sp == 3) ? 1 : int'(sp));
                3: a = whi((sp == 3) ? 1 : int'(sp)) + 64'd1;
                default: a = {32'($urandom_range(0, 3)), 32'($urandom)};
            endcase
            drive(($urandom_range(0, 2) == 0), off, 4'($urandom), 32'($urandom),
                  ($urandom_range(0, 40) == 0), sp, a);
        end

        rd(8'h00);
        rd(8'h00);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule